// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block sits between a processor's entry sequencer and the interrupt request lines of a chip. Each cycle it looks at a system reset request, three non-maskable fault sources with their own enables, and a vector of peripheral request flags with per-source enables and a global enable from the status register. It chooses one winner by fixed priority and publishes the 16-bit word address of that winner's slot in the vector table, together with a one-cycle accept strobe.

When a choice is made, the block also sends one-cycle pulses back to the sources. A peripheral that owns its vector slot alone gets its flag cleared. A slot shared by several peripherals leaves its flags for software to clear. Taking the non-maskable slot clears all three fault enables. The chosen address is then held until the sequencer signals that the vector has been fetched. Only a reset request can replace the held choice.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle: `accept`, `busy`, `flag_clr` and `nmi_en_clr` are zero, and `vec_addr` reads 0xFFFE.
- R2: A peripheral source i counts as a request only when `irq_flag[i]`, `irq_en[i]` and `gie` are all 1. Otherwise no accept is produced for it.
- R3: Among peripheral requests, the lowest index wins. Source i is presented at address 0xFFFA − 2·i, so a higher table address means higher priority.
- R4: A non-maskable request is any bit set in `nmi_flag & nmi_en`. It is accepted whatever the value of `gie`, beats every peripheral request, and is presented at address 0xFFFC.
- R5: In the accept cycle of a non-maskable request, `nmi_en_clr` is 3'b111. For any other accept, and in every other cycle, it is 0.
- R6: `accept` is high for exactly one cycle, the cycle after the edge that sampled the request. `busy` then stays high and `vec_addr` stays unchanged until `ack` is sampled. No further accept happens in that time except the one R8 allows.
- R7: In the accept cycle of peripheral source i, `flag_clr` is one-hot at bit i when bit i of SHARED_MASK is 0. It is all zero when bit i of SHARED_MASK is 1 (default SHARED_MASK = 8'h24, so sources 2 and 5 are shared).
- R8: `rst_req` is level-sensitive and beats every other request, at address 0xFFFE. If it rises while a non-reset choice is held, a new accept with 0xFFFE follows on the next edge.
- R9: The cycle after `ack` is sampled, `busy` is low, and a pending request is accepted at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req | input | 1 | System reset request, level |
| nmi_flag | input | 3 | Non-maskable source flags (oscillator fault, external pin, flash access violation) |
| nmi_en | input | 3 | Enables for the non-maskable sources |
| irq_flag | input | N_SRC | Peripheral request flags, index 0 highest priority |
| irq_en | input | N_SRC | Per-peripheral enables |
| gie | input | 1 | Global enable from the status register |
| ack | input | 1 | Sequencer has fetched the presented vector |
| accept | output | 1 | One-cycle strobe: a new choice is presented |
| busy | output | 1 | A choice is held, waiting for `ack` |
| vec_addr | output | 16 | Vector table word address of the choice |
| flag_clr | output | N_SRC | One-cycle flag-clear pulse to peripheral sources |
| nmi_en_clr | output | 3 | One-cycle enable-clear pulse to non-maskable sources |

## Verification
The bench sweeps every flag pattern against several enable patterns with `gie` both ways. A mistake in masking or in the order of the priority encoder shows up as a wrong address or as a missing or extra accept. Non-maskable flag and enable pairs are swept with `gie` low and peripheral requests also pending. A design that gated them with `gie` or ranked them below peripherals would present 0xFFFA-range addresses or nothing, and one that forgot the enable-clear would leave `nmi_en_clr` at zero. Shared-slot sources check that their flags are not cleared. A held choice is hit with new requests to show the address stays put and no second strobe fires. A reset request arriving mid-hold must re-strobe at 0xFFFE, and a design that ignored it until `ack` would stay silent.

// File: rtl/irq_arb_pkg.sv
// Package: shared types and fixed table addresses for the interrupt arbiter.
// Assumes a 16-bit vector table whose top slots hold reset and the
// non-maskable entry, with peripheral slots packed downward below them.
package irq_arb_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RST  = 2'd1,
        SEL_NMI  = 2'd2,
        SEL_MASK = 2'd3
    } sel_kind_t;

    localparam logic [15:0] VEC_RESET    = 16'hFFFE;
    localparam logic [15:0] VEC_NMI      = 16'hFFFC;
    localparam logic [15:0] VEC_MASK_TOP = 16'hFFFA;
    localparam int          NMI_SRC      = 3;

endpackage

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker. Reports whether any bit of req is set and
// the index of the lowest set bit (index 0 ranks highest).
// Assumes N >= 1; output index is zero when nothing is set.
module irq_prio_pick #(
    parameter int N    = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic            hit,
    output logic [IDXW-1:0] idx
);

    // Scan downward so the lowest set index is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end

    // Any request present.
    assign hit = |req;

endmodule

// File: rtl/irq_winner_sel.sv
// Module: combinational winner selection. Applies the masking rules, ranks
// reset over non-maskable over peripheral sources, and builds the table
// address and the flag-clear vector for the winner.
// Assumes SHARED marks peripheral slots owned by more than one source.
module irq_winner_sel
    import irq_arb_pkg::*;
#(
    parameter int          N      = 8,
    parameter logic [N-1:0] SHARED = '0,
    localparam int         IDXW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic               rst_req,
    input  logic [NMI_SRC-1:0] nmi_flag,
    input  logic [NMI_SRC-1:0] nmi_en,
    input  logic [N-1:0]       irq_flag,
    input  logic [N-1:0]       irq_en,
    input  logic               gie,
    output sel_kind_t          kind,
    output logic [15:0]        addr,
    output logic [N-1:0]       clr
);

    logic [N-1:0]    eligible;
    logic            mask_hit;
    logic [IDXW-1:0] mask_idx;
    logic            nmi_hit;

    // Per-source eligibility: own flag, own enable and global enable.
    for (genvar g = 0; g < N; g++) begin : g_elig
        assign eligible[g] = irq_flag[g] & irq_en[g] & gie;
    end

    irq_prio_pick #(.N(N)) u_pick (
        .req (eligible),
        .hit (mask_hit),
        .idx (mask_idx)
    );

    // Non-maskable sources ignore the global enable.
    assign nmi_hit = |(nmi_flag & nmi_en);

    // Rank the three classes and form the table address.
    always_comb begin
        kind = SEL_NONE;
        addr = VEC_RESET;
        if (rst_req) begin
            kind = SEL_RST;
            addr = VEC_RESET;
        end else if (nmi_hit) begin
            kind = SEL_NMI;
            addr = VEC_NMI;
        end else if (mask_hit) begin
            kind = SEL_MASK;
            addr = VEC_MASK_TOP - (16'(mask_idx) << 1);
        end
    end

    // Flag clear only for a winning peripheral that owns its slot alone.
    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr[g] = (kind == SEL_MASK) && (mask_idx == IDXW'(g)) && !SHARED[g];
    end

endmodule

// File: rtl/irq_vector_arbiter.sv
// Module: top of the interrupt arbiter. Registers the winner from
// irq_winner_sel, strobes accept for one cycle, pulses the source clears,
// and holds the address until the sequencer acks. A reset request
// replaces any non-reset choice already held.
// Assumes ack is only raised while busy; synchronous active-low rst_n.
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int           N_SRC       = 8,
    parameter logic [N_SRC-1:0] SHARED_MASK = 8'h24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic [NMI_SRC-1:0] nmi_flag,
    input  logic [NMI_SRC-1:0] nmi_en,
    input  logic [N_SRC-1:0]   irq_flag,
    input  logic [N_SRC-1:0]   irq_en,
    input  logic               gie,
    input  logic               ack,
    output logic               accept,
    output logic               busy,
    output logic [15:0]        vec_addr,
    output logic [N_SRC-1:0]   flag_clr,
    output logic [NMI_SRC-1:0] nmi_en_clr
);

    sel_kind_t          sel_kind;
    logic [15:0]        sel_addr;
    logic [N_SRC-1:0]   sel_clr;
    sel_kind_t          held_kind_q;
    logic               take;

    irq_winner_sel #(.N(N_SRC), .SHARED(SHARED_MASK)) u_sel (
        .rst_req  (rst_req),
        .nmi_flag (nmi_flag),
        .nmi_en   (nmi_en),
        .irq_flag (irq_flag),
        .irq_en   (irq_en),
        .gie      (gie),
        .kind     (sel_kind),
        .addr     (sel_addr),
        .clr      (sel_clr)
    );

    // Accept when idle with a winner, or when reset preempts a held choice.
    assign take = (!busy && (sel_kind != SEL_NONE)) ||
                  (busy && rst_req && (held_kind_q != SEL_RST));

    // Hold/accept state, address register and one-cycle clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            accept      <= 1'b0;
            vec_addr    <= VEC_RESET;
            flag_clr    <= '0;
            nmi_en_clr  <= '0;
            held_kind_q <= SEL_NONE;
        end else begin
            accept     <= 1'b0;
            flag_clr   <= '0;
            nmi_en_clr <= '0;
            if (take) begin
                busy        <= 1'b1;
                accept      <= 1'b1;
                vec_addr    <= sel_addr;
                held_kind_q <= sel_kind;
                flag_clr    <= sel_clr;
                nmi_en_clr  <= (sel_kind == SEL_NMI) ? '1 : '0;
            end else if (busy && ack) begin
                busy        <= 1'b0;
                held_kind_q <= SEL_NONE;
            end
        end
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rst_req |=> !accept);                                   // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ack && !rst_req |=> $stable(vec_addr));                 // R6
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> busy);                                                // R6
    AST_NMI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_en_clr != '0) |-> accept && (vec_addr == VEC_NMI));         // R5
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr != '0) |-> accept && ($countones(flag_clr) == 1));     // R7
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (held_kind_q == SEL_MASK) |-> $past(gie));             // R2
    AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(rst_req) == (vec_addr == VEC_RESET)));         // R8

endmodule

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;

    localparam int         N      = 8;
    localparam logic [7:0] SHARED = 8'h24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic [2:0] nmi_flag = '0, nmi_en = '0;
    logic [N-1:0] irq_flag = '0, irq_en = '0;
    logic       gie = 1'b0, ack = 1'b0;
    logic       accept, busy;
    logic [15:0] vec_addr;
    logic [N-1:0] flag_clr;
    logic [2:0] nmi_en_clr;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_vector_arbiter #(.N_SRC(N), .SHARED_MASK(SHARED)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .nmi_flag(nmi_flag), .nmi_en(nmi_en),
        .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .ack(ack),
        .accept(accept), .busy(busy), .vec_addr(vec_addr),
        .flag_clr(flag_clr), .nmi_en_clr(nmi_en_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Release a held choice and return to idle with all requests quiet.
    task automatic release_hold();
        @(negedge clk);
        irq_flag = '0; nmi_flag = '0; rst_req = 1'b0; ack = 1'b1;
        step();
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 accept", accept, 0);
        chk("R1 busy", busy, 0);
        chk("R1 vec", vec_addr, 16'hFFFE);
        chk("R1 clr", {flag_clr, nmi_en_clr}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R7: sweep peripheral patterns
        for (int f = 0; f < 256; f++) begin
            for (int e = 0; e < 4; e++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [7:0] en, m, exp_clr;
                    int win;
                    en = (e == 0) ? 8'hFF : (e == 1) ? 8'h5A : (e == 2) ? 8'hA5 : (8'(f) ^ 8'h3C);
                    m = 8'(f) & en & {8{g[0]}};
                    win = -1;
                    for (int i = 7; i >= 0; i--) if (m[i]) win = i;
                    @(negedge clk);
                    irq_flag = 8'(f); irq_en = en; gie = g[0];
                    step();
                    if (win < 0) begin
                        chk("R2 no accept", accept, 0);
                    end else begin
                        exp_clr = SHARED[win] ? 8'h00 : (8'h01 << win);
                        chk("R3 accept", accept, 1);
                        chk("R3 vec", vec_addr, 16'hFFFA - 16'(2 * win));
                        chk("R7 flag_clr", {flag_clr, nmi_en_clr}, {exp_clr, 3'b000});
                        step();
                        chk("R6 single strobe", accept, 0);
                        release_hold();
                    end
                end
            end
        end

        // R4 R5: non-maskable sweep with gie low and peripherals pending
        for (int nf = 0; nf < 8; nf++) begin
            for (int ne = 0; ne < 8; ne++) begin
                logic hitn;
                hitn = (3'(nf) & 3'(ne)) != 0;
                @(negedge clk);
                nmi_flag = 3'(nf); nmi_en = 3'(ne);
                irq_flag = 8'h81; irq_en = 8'hFF; gie = 1'b0;
                step();
                if (hitn) begin
                    chk("R4 accept", accept, 1);
                    chk("R4 vec", vec_addr, 16'hFFFC);
                    chk("R5 nmi_en_clr", nmi_en_clr, 3'b111);
                    chk("R5 no flag_clr", flag_clr, 0);
                    step();
                    chk("R5 pulse end", nmi_en_clr, 0);
                    release_hold();
                end else begin
                    chk("R4 none", accept, 0);
                end
            end
        end
        @(negedge clk); nmi_flag = '0; nmi_en = '0;

        // R4: nmi beats peripheral with gie high
        @(negedge clk);
        nmi_flag = 3'b010; nmi_en = 3'b010; irq_flag = 8'h01; irq_en = 8'hFF; gie = 1'b1;
        step();
        chk("R4 over mask", vec_addr, 16'hFFFC);
        release_hold();
        @(negedge clk); nmi_flag = '0;

        // R6: hold while new requests arrive, then R9 release
        @(negedge clk);
        irq_flag = 8'h10; irq_en = 8'hFF; gie = 1'b1;
        step();
        chk("R6 accept", vec_addr, 16'hFFF2);
        @(negedge clk);
        irq_flag = 8'h01; nmi_flag = 3'b001; nmi_en = 3'b001;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R6 no strobe", accept, 0);
            chk("R6 vec held", vec_addr, 16'hFFF2);
            chk("R6 busy", busy, 1);
        end
        @(negedge clk); ack = 1'b1;
        step();
        chk("R9 busy drop", busy, 0);
        chk("R9 no accept at ack", accept, 0);
        @(negedge clk); ack = 1'b0;
        step();
        chk("R9 next accept", accept, 1);
        chk("R9 next vec", vec_addr, 16'hFFFC);
        release_hold();
        @(negedge clk); nmi_flag = '0; nmi_en = '0;

        // R8: reset over nmi, and preemption of a held peripheral choice
        @(negedge clk);
        rst_req = 1'b1; nmi_flag = 3'b100; nmi_en = 3'b100; irq_flag = 8'hFF;
        step();
        chk("R8 reset first", vec_addr, 16'hFFFE);
        chk("R8 no nmi clr", nmi_en_clr, 0);
        step();
        chk("R8 no restrobe", accept, 0);
        release_hold();
        @(negedge clk); nmi_flag = '0; nmi_en = '0;
        @(negedge clk); irq_flag = 8'h04; irq_en = 8'hFF; gie = 1'b1;
        step();
        chk("R8 held mask", vec_addr, 16'hFFF6);
        chk("R7 shared no clr", flag_clr, 0);
        @(negedge clk); rst_req = 1'b1;
        step();
        chk("R8 preempt strobe", accept, 1);
        chk("R8 preempt vec", vec_addr, 16'hFFFE);
        release_hold();

        // R1: reset mid-hold returns to idle
        @(negedge clk); irq_flag = 8'h02;
        step();
        @(negedge clk); rst_n = 1'b0; irq_flag = '0;
        step();
        chk("R1 busy cleared", busy, 0);
        chk("R1 vec", vec_addr, 16'hFFFE);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule